// File: doc/BRIEF.md
# Vacuum Fluorescent Display Refresh Word Sequencer

This block produces the continuous refresh stream for a multiplexed display of twelve 14-segment character cells. It keeps a content store for every cell (segments, three separator marks, a text label bit and a blink enable). The rightmost cell also has two unit indicator bits. It also keeps four highlight slots, each able to name one cell that gets an extra strobe per frame. From this store it forms a 32-bit word for every slot of a 16-slot frame. Each word goes to a serial transmitter through a valid/ready pair.

Software-side writes land in a shadow copy. The shadow is copied to the live copy only when the last word of a frame is accepted, so every frame is built from a single snapshot. A frame-counting blink phase blanks the segments of blink-enabled cells in their normal word. The highlight word keeps the cell lit, so a blinking cell alternates between a bright state and a blank state.

Top module: `vfd_frame_seq`

## Requirements
- R1: While reset is held, `word_valid` is low. The first frame after reset shows every character word as its gate bit alone and every highlight word as 0x80000000.
- R2: With HL_FIRST=0, frame slots 0..11 carry cell positions 11 down to 0 and slots 12..15 carry highlight slots 0..3. With HL_FIRST=1 the four highlight words come first.
- R3: Bits 31..20 hold a one-hot gate; bit 20+p selects cell p (cell 0 is the rightmost).
- R4: In a character word, segment s (s<8) goes to bit s and segment s (s>=8) goes to bit s+2. Separators sit at bits 18..16 and the label at bit 19.
- R5: The unit indicator pair of cell 0 appears at bits 9..8 of its word. Unit values written to any other cell are ignored and those bits stay 0.
- R6: An enabled highlight slot whose target is below 12 sends the target's gate bit plus its 14 segment bits only. Separators, label and units stay 0.
- R7: A disabled highlight slot, or one whose target is 12 or more, sends 0x80000000.
- R8: The blink phase starts at "shown" and toggles every BLINK_FRAMES frames. In the blanked phase a blink-enabled cell's character word has its segment bits cleared while separators and label remain. Its highlight word is not blanked.
- R9: A write lands in the first frame that starts after it. A frame already in progress keeps its old content for all of its slots.
- R10: A word is consumed only when `word_valid` and `word_ready` are both high. While stalled, `word_data` holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_en | input | 1 | Cell write strobe |
| cw_pos | input | 4 | Cell to write (0 = rightmost) |
| cw_seg | input | 14 | Segment pattern |
| cw_sep | input | 3 | Separator marks |
| cw_lbl | input | 1 | Text label bit |
| cw_unit | input | 2 | Unit indicators (kept for cell 0 only) |
| cw_blink | input | 1 | Blink enable of the cell |
| hw_en | input | 1 | Highlight slot write strobe |
| hw_slot | input | 2 | Highlight slot to write |
| hw_on | input | 1 | Highlight slot enable |
| hw_pos | input | 4 | Cell the highlight slot points at |
| word_ready | input | 1 | Transmitter accepts the current word |
| word_valid | output | 1 | A refresh word is presented |
| word_data | output | 32 | Refresh word |

## Verification
The bench builds the block with BLINK_FRAMES set to 2 and the default slot order. Several full blink half-periods therefore fit in a dozen frames, and the shown-to-blank and blank-to-shown edges are checked against a frame count kept by the bench. Twelve cells and four highlight slots stay at their defaults, so every gate position, the out-of-range highlight target and the cell-0 unit bits are reached with real field positions. Writes are placed both between frames and in the middle of a frame, which brings the snapshot boundary into view.

// File: rtl/vfdseq_pkg.sv
package vfdseq_pkg;
  localparam int WORD_W   = 32;
  localparam int SEG_W    = 14;
  localparam int SEP_W    = 3;
  localparam int UNIT_W   = 2;
  localparam int SEP_LSB  = 16;
  localparam int LBL_BIT  = 19;
  localparam int UNIT_LSB = 8;

  typedef struct packed {
    logic              blink;
    logic              lbl;
    logic [SEP_W-1:0]  sep;
    logic [UNIT_W-1:0] unit;
    logic [SEG_W-1:0]  seg;
  } cell_t;

  // Segments 13..8 sit above the two unit bits, 7..0 sit at the bottom.
  function automatic logic [WORD_W-1:0] seg_field(input logic [SEG_W-1:0] s);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[15:10] = s[13:8];
    w[7:0]   = s[7:0];
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] gate_field(input int base, input int pos);
    return WORD_W'(1) << (base + pos);
  endfunction
endpackage

// File: rtl/vfd_regbank.sv
module vfd_regbank
  import vfdseq_pkg::*;
#(
  parameter int NUM_POS = 12,
  parameter int NUM_HL  = 4,
  localparam int POS_W  = $clog2(NUM_POS),
  localparam int HL_W   = $clog2(NUM_HL)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic                           cw_en,
  input  logic [POS_W-1:0]               cw_pos,
  input  cell_t                          cw_cell,
  input  logic                           hw_en,
  input  logic [HL_W-1:0]                hw_slot,
  input  logic                           hw_on,
  input  logic [POS_W-1:0]               hw_pos,
  output cell_t [NUM_POS-1:0]            act_cells,
  output logic  [NUM_HL-1:0]             act_hl_on,
  output logic  [NUM_HL-1:0][POS_W-1:0]  act_hl_pos
);
  for (genvar p = 0; p < NUM_POS; p++) begin : g_cell
    cell_t sh_q, act_q, wr_c;
    always_comb begin
      wr_c = cw_cell;
      if (p != 0) wr_c.unit = '0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        if (cw_en && cw_pos == POS_W'(p)) sh_q <= wr_c;
        if (load) act_q <= sh_q;
      end
    end
    assign act_cells[p] = act_q;
  end

  for (genvar k = 0; k < NUM_HL; k++) begin : g_hl
    logic             sh_on_q, act_on_q;
    logic [POS_W-1:0] sh_pos_q, act_pos_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_on_q   <= 1'b0;
        sh_pos_q  <= '0;
        act_on_q  <= 1'b0;
        act_pos_q <= '0;
      end else begin
        if (hw_en && hw_slot == HL_W'(k)) begin
          sh_on_q  <= hw_on;
          sh_pos_q <= hw_pos;
        end
        if (load) begin
          act_on_q  <= sh_on_q;
          act_pos_q <= sh_pos_q;
        end
      end
    end
    assign act_hl_on[k]  = act_on_q;
    assign act_hl_pos[k] = act_pos_q;
  end
endmodule

// File: rtl/vfd_slot_ctrl.sv
module vfd_slot_ctrl #(
  parameter int TOTAL        = 16,
  parameter int BLINK_FRAMES = 32,
  localparam int SLOT_W      = $clog2(TOTAL),
  localparam int BC_W        = $clog2(BLINK_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_ready,
  output logic              word_valid,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_end,
  output logic              blank_phase
);
  logic              valid_q, phase_q, accept;
  logic [SLOT_W-1:0] slot_q;
  logic [BC_W-1:0]   bcnt_q;

  assign accept    = valid_q & word_ready;
  assign frame_end = accept && (slot_q == SLOT_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      slot_q  <= '0;
      bcnt_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      valid_q <= 1'b1;
      if (accept) slot_q <= frame_end ? '0 : slot_q + 1'b1;
      if (frame_end) begin
        if (bcnt_q == BC_W'(BLINK_FRAMES - 1)) begin
          bcnt_q  <= '0;
          phase_q <= ~phase_q;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  assign word_valid  = valid_q;
  assign slot        = slot_q;
  assign blank_phase = phase_q;
endmodule

// File: rtl/vfd_word_mux.sv
module vfd_word_mux
  import vfdseq_pkg::*;
#(
  parameter int NUM_POS  = 12,
  parameter int NUM_HL   = 4,
  parameter int HL_FIRST = 0,
  localparam int TOTAL   = NUM_POS + NUM_HL,
  localparam int SLOT_W  = $clog2(TOTAL),
  localparam int POS_W   = $clog2(NUM_POS),
  localparam int HL_W    = $clog2(NUM_HL),
  localparam int GATE_LSB = WORD_W - NUM_POS
) (
  input  logic [SLOT_W-1:0]              slot,
  input  logic                           blank_phase,
  input  cell_t [NUM_POS-1:0]            cells,
  input  logic  [NUM_HL-1:0]             hl_on,
  input  logic  [NUM_HL-1:0][POS_W-1:0]  hl_pos,
  output logic                           is_hl,
  output logic  [WORD_W-1:0]             word
);
  int               idx;
  logic [HL_W-1:0]  k;
  logic [POS_W-1:0] cpos, tpos, tsafe;
  logic             tok;
  cell_t            cc, tc;

  if (HL_FIRST != 0) begin : g_hl_first
    assign is_hl = int'(slot) < NUM_HL;
    assign idx   = is_hl ? int'(slot) : int'(slot) - NUM_HL;
  end else begin : g_chars_first
    assign is_hl = int'(slot) >= NUM_POS;
    assign idx   = is_hl ? int'(slot) - NUM_POS : int'(slot);
  end

  assign k     = HL_W'(idx);
  assign cpos  = POS_W'(NUM_POS - 1 - idx);
  assign tpos  = hl_pos[k];
  assign tok   = hl_on[k] && (int'(tpos) < NUM_POS);
  assign tsafe = tok ? tpos : '0;
  assign cc    = cells[cpos];
  assign tc    = cells[tsafe];

  always_comb begin
    word = '0;
    if (is_hl) begin
      if (tok) word = gate_field(GATE_LSB, int'(tsafe)) | seg_field(tc.seg);
      else     word = gate_field(GATE_LSB, NUM_POS - 1);
    end else begin
      word = gate_field(GATE_LSB, int'(cpos))
           | seg_field((blank_phase && cc.blink) ? '0 : cc.seg);
      word[SEP_LSB +: SEP_W] = cc.sep;
      word[LBL_BIT]          = cc.lbl;
      if (cpos == '0) word[UNIT_LSB +: UNIT_W] = cc.unit;
    end
  end
endmodule

// File: rtl/vfd_frame_seq.sv
module vfd_frame_seq
  import vfdseq_pkg::*;
#(
  parameter int NUM_POS      = 12,
  parameter int NUM_HL       = 4,
  parameter int BLINK_FRAMES = 32,
  parameter int HL_FIRST     = 0,
  localparam int TOTAL       = NUM_POS + NUM_HL,
  localparam int SLOT_W      = $clog2(TOTAL),
  localparam int POS_W       = $clog2(NUM_POS),
  localparam int HL_W        = $clog2(NUM_HL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_en,
  input  logic [POS_W-1:0]  cw_pos,
  input  logic [SEG_W-1:0]  cw_seg,
  input  logic [SEP_W-1:0]  cw_sep,
  input  logic              cw_lbl,
  input  logic [UNIT_W-1:0] cw_unit,
  input  logic              cw_blink,
  input  logic              hw_en,
  input  logic [HL_W-1:0]   hw_slot,
  input  logic              hw_on,
  input  logic [POS_W-1:0]  hw_pos,
  input  logic              word_ready,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  // Named internal events, observed by the bound checker.
  logic              frame_end_w, blank_w, hl_slot_w;
  logic [SLOT_W-1:0] slot_w;
  cell_t             wr_cell;
  cell_t [NUM_POS-1:0]           cells_w;
  logic  [NUM_HL-1:0]            hl_on_w;
  logic  [NUM_HL-1:0][POS_W-1:0] hl_pos_w;

  assign wr_cell = '{blink: cw_blink, lbl: cw_lbl, sep: cw_sep, unit: cw_unit, seg: cw_seg};

  vfd_slot_ctrl #(.TOTAL(TOTAL), .BLINK_FRAMES(BLINK_FRAMES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .word_ready(word_ready), .word_valid(word_valid),
    .slot(slot_w), .frame_end(frame_end_w), .blank_phase(blank_w)
  );

  vfd_regbank #(.NUM_POS(NUM_POS), .NUM_HL(NUM_HL)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(frame_end_w),
    .cw_en(cw_en), .cw_pos(cw_pos), .cw_cell(wr_cell),
    .hw_en(hw_en), .hw_slot(hw_slot), .hw_on(hw_on), .hw_pos(hw_pos),
    .act_cells(cells_w), .act_hl_on(hl_on_w), .act_hl_pos(hl_pos_w)
  );

  vfd_word_mux #(.NUM_POS(NUM_POS), .NUM_HL(NUM_HL), .HL_FIRST(HL_FIRST)) u_mux (
    .slot(slot_w), .blank_phase(blank_w), .cells(cells_w),
    .hl_on(hl_on_w), .hl_pos(hl_pos_w), .is_hl(hl_slot_w), .word(word_data)
  );
endmodule

// File: rtl/vfd_frame_seq_chk.sv
module vfd_frame_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic        word_ready,
  input logic [31:0] word_data,
  input logic        hl_slot_w,
  input logic        blank_w,
  input logic        frame_end_w
);
  assert_valid_low_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !word_valid);

  assert_gate_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $countones(word_data[31:20]) == 1);

  assert_units_only_cell0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_data[20]) |-> word_data[9:8] == 2'b00);

  assert_hl_segments_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && hl_slot_w) |-> (word_data[19:16] == 4'h0 && word_data[9:8] == 2'b00));

  assert_phase_frame_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_w |=> $stable(blank_w));

  assert_stall_holds_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));
endmodule

bind vfd_frame_seq vfd_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
  .word_data(word_data), .hl_slot_w(hl_slot_w), .blank_w(blank_w),
  .frame_end_w(frame_end_w)
);

// File: tb/vfd_frame_seq_tb_top.sv
module vfd_frame_seq_tb_top;
  localparam int BF = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cw_en = 0, cw_lbl = 0, cw_blink = 0, hw_en = 0, hw_on = 0, word_ready = 0;
  logic [3:0]  cw_pos = 0, hw_pos = 0;
  logic [13:0] cw_seg = 0;
  logic [2:0]  cw_sep = 0;
  logic [1:0]  cw_unit = 0, hw_slot = 0;
  logic        word_valid;
  logic [31:0] word_data;

  vfd_frame_seq #(.BLINK_FRAMES(BF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_pos(cw_pos), .cw_seg(cw_seg),
    .cw_sep(cw_sep), .cw_lbl(cw_lbl), .cw_unit(cw_unit), .cw_blink(cw_blink),
    .hw_en(hw_en), .hw_slot(hw_slot), .hw_on(hw_on), .hw_pos(hw_pos),
    .word_ready(word_ready), .word_valid(word_valid), .word_data(word_data)
  );

  int n_chk = 0, n_fail = 0, words = 0;
  bit done = 0;

  // Reference model: shadow (s_) and live (a_) copies.
  logic [13:0] s_seg[12], a_seg[12];
  logic [2:0]  s_sep[12], a_sep[12];
  logic        s_lbl[12], a_lbl[12], s_blk[12], a_blk[12];
  logic [1:0]  s_unit, a_unit;
  logic        s_hon[4], a_hon[4];
  logic [3:0]  s_hpos[4], a_hpos[4];

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h (word %0d)", req, act, exp, words);
    end
  endtask

  function automatic logic [31:0] put_segs(logic [13:0] sg);
    logic [31:0] w;
    w = 0;
    for (int i = 0; i < 14; i++) if (sg[i]) w[(i < 8) ? i : i + 2] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] exp_word(int s, bit ph);
    logic [31:0] w;
    int p, k;
    w = 0;
    if (s < 12) begin
      p = 11 - s;
      w[20 + p] = 1'b1;
      w = w | put_segs((ph && a_blk[p]) ? 14'h0 : a_seg[p]);
      w[16 +: 3] = a_sep[p];
      w[19] = a_lbl[p];
      if (p == 0) w[8 +: 2] = a_unit;
    end else begin
      k = s - 12;
      if (a_hon[k] && a_hpos[k] < 12) begin
        w[20 + int'(a_hpos[k])] = 1'b1;
        w = w | put_segs(a_seg[a_hpos[k]]);
      end else w = 32'h8000_0000;
    end
    return w;
  endfunction

  task automatic model_load();
    for (int i = 0; i < 12; i++) begin
      a_seg[i] = s_seg[i]; a_sep[i] = s_sep[i]; a_lbl[i] = s_lbl[i]; a_blk[i] = s_blk[i];
    end
    a_unit = s_unit;
    for (int i = 0; i < 4; i++) begin a_hon[i] = s_hon[i]; a_hpos[i] = s_hpos[i]; end
  endtask

  task automatic get_word(output logic [31:0] w);
    @(negedge clk);
    word_ready = 1'b1;
    while (!word_valid) @(negedge clk);
    w = word_data;
    @(negedge clk);
    word_ready = 1'b0;
    words++;
    if (words % 16 == 0) model_load();
  endtask

  task automatic check_words(string req, int from, int upto);
    logic [31:0] w;
    bit ph;
    ph = ((words / 16) / BF) % 2 == 1;
    for (int s = from; s < upto; s++) begin
      get_word(w);
      check32(req, w, exp_word(s, ph));
    end
  endtask

  task automatic run_frame(string req);
    check_words(req, 0, 16);
  endtask

  task automatic cwrite(int pos, logic [13:0] sg, logic [2:0] sp, logic lb, logic [1:0] un, logic bk);
    @(negedge clk);
    cw_en = 1; cw_pos = 4'(pos); cw_seg = sg; cw_sep = sp; cw_lbl = lb; cw_unit = un; cw_blink = bk;
    @(negedge clk);
    cw_en = 0;
    if (pos < 12) begin
      s_seg[pos] = sg; s_sep[pos] = sp; s_lbl[pos] = lb; s_blk[pos] = bk;
      if (pos == 0) s_unit = un;
    end
  endtask

  task automatic hwrite(int slot, logic on, int pos);
    @(negedge clk);
    hw_en = 1; hw_slot = 2'(slot); hw_on = on; hw_pos = 4'(pos);
    @(negedge clk);
    hw_en = 0;
    s_hon[slot] = on; s_hpos[slot] = 4'(pos);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check32("R1 valid in reset", {31'd0, word_valid}, 32'd0);
    rst_n = 1'b1;
    run_frame("R1 first frame blank");
  endtask

  task automatic t_chars();
    cwrite(11, 14'h3FFF, 3'b000, 1'b0, 2'b00, 1'b0);
    cwrite(5, 14'h2A55, 3'b101, 1'b1, 2'b00, 1'b0);
    cwrite(3, 14'h0100, 3'b010, 1'b0, 2'b00, 1'b0);
    run_frame("R9 old snapshot");
    run_frame("R2/R3/R4 fields");
  endtask

  task automatic t_units();
    cwrite(0, 14'h00C3, 3'b111, 1'b1, 2'b10, 1'b0);
    cwrite(6, 14'h1001, 3'b001, 1'b0, 2'b11, 1'b0);
    run_frame("R5 settle");
    run_frame("R5 units cell0 only");
    cwrite(0, 14'h00C3, 3'b111, 1'b1, 2'b01, 1'b0);
    run_frame("R5 settle");
    run_frame("R5 other unit code");
  endtask

  task automatic t_highlight();
    hwrite(0, 1'b1, 5);
    hwrite(1, 1'b1, 0);
    hwrite(2, 1'b1, 13);
    hwrite(3, 1'b0, 3);
    run_frame("R6 settle");
    run_frame("R6/R7 highlight words");
  endtask

  task automatic t_midframe();
    check_words("R9 head", 0, 5);
    cwrite(11, 14'h0001, 3'b000, 1'b0, 2'b00, 1'b0);
    cwrite(2, 14'h0F0F, 3'b100, 1'b1, 2'b00, 1'b0);
    check_words("R9 tail keeps old", 5, 16);
    run_frame("R9 new content");
  endtask

  task automatic t_blink();
    cwrite(5, 14'h2A55, 3'b101, 1'b1, 2'b00, 1'b1);
    cwrite(2, 14'h0F0F, 3'b100, 1'b1, 2'b00, 1'b1);
    for (int f = 0; f < 8; f++) run_frame("R8 blink");
  endtask

  task automatic t_stall();
    bit ph;
    ph = ((words / 16) / BF) % 2 == 1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check32("R10 stalled word", word_data, exp_word(0, ph));
    end
    run_frame("R10 after stall");
  endtask

  initial begin
    for (int i = 0; i < 12; i++) begin
      s_seg[i] = 0; s_sep[i] = 0; s_lbl[i] = 0; s_blk[i] = 0;
    end
    s_unit = 0;
    for (int i = 0; i < 4; i++) begin s_hon[i] = 0; s_hpos[i] = 0; end
    model_load();
    t_reset();
    t_chars();
    t_units();
    t_highlight();
    t_midframe();
    t_blink();
    t_stall();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule